// File: doc/BRIEF.md
# Random-Access Scan Observation Tree

This block brings the value of one addressed scan cell out to a single scan-out pin. Every scan cell supplies two signals: its stored bit and a select line that the address decoder raises when that cell is the one being read. The block folds these signals through a tree of four-input macrocells. Each macrocell passes on one data bit and one control bit. The control bit shows that some cell in that macrocell's subtree is selected. The tree has LEVELS stages and serves 4**LEVELS cells. With the default of two levels it serves a 16-cell group: four leaf macrocells feed one root macrocell.

A build-time parameter, PIPE, chooses where the outputs of the macrocells are taken. With PIPE=0 they are combinational, and the pin follows the addressed cell in the same cycle. With PIPE=1 every macrocell registers both of its outputs. Observation then takes several cycles, but each wire spans only a single tree level, and a new address can be presented on every cycle. The scan_valid output plays the role of a stream valid for the observed bit. The pin takes no back-pressure: a consumer must sample each result in the cycle it appears. Storage of the cells and decoding of the address happen elsewhere and reach this block as inputs.

Top module: `ras_scanout_tree`

## Requirements
- R1: When exactly one cell_sel bit k is high, scan_out equals cell_data[k] once the latency of R4 or R5 has elapsed.
- R2: scan_valid is 1 exactly when at least one cell_sel bit is high, with the same latency as scan_out.
- R3: When every cell_sel bit is low, scan_out is 0 and scan_valid is 0, whatever the values on cell_data.
- R4: With PIPE=0, scan_out and scan_valid follow the inputs in the same cycle, with no clock edge in between.
- R5: With PIPE=1, the inputs present before a rising clock edge appear on scan_out and scan_valid after LEVELS rising edges. A new input pattern may be applied on every cycle.
- R6: With PIPE=1, scan_out and scan_valid are 0 while rst_n is low.
- R7: When more than one cell_sel bit is high, scan_out is the OR of the data bits of all selected cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers between levels |
| rst_n | input | 1 | Asynchronous reset, active low |
| cell_data | input | 4**LEVELS | Stored bit of each scan cell |
| cell_sel | input | 4**LEVELS | Select line of each scan cell from the address decoder |
| scan_out | output | 1 | Observed bit of the selected cell |
| scan_valid | output | 1 | High when a cell is selected |

## Verification
With PIPE=0, a result is due as soon as the inputs settle. The bench therefore checks that instance one time unit after it drives the inputs on a falling edge, and no rising edge falls in between. With PIPE=1, a result is due after LEVELS rising edges (two for 16 cells). The directed and random checks wait exactly that many edges while holding the inputs steady. A streaming run changes the inputs on every falling edge. In that run, each output is compared with the expected value of the pattern driven LEVELS falling edges earlier, which the bench keeps in a short history array.

// File: rtl/ras_so_pkg.sv
package ras_so_pkg;
  localparam int FANIN = 4;
  localparam int FANIN_LOG2 = 2;

  function automatic int cells_for(input int levels);
    return 1 << (FANIN_LOG2 * levels);
  endfunction
endpackage

// File: rtl/ras_so_macrocell.sv
module ras_so_macrocell #(
  parameter bit PIPE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] din,
  input  logic [3:0] cin,
  output logic       dout,
  output logic       cout
) ;
  logic d_next;
  logic c_next;

  // Gate each bit by its select line, so an unselected cell contributes 0.
  assign d_next = |(din & cin);
  assign c_next = |cin;

  generate
    if (PIPE) begin : g_reg
      logic d_q;
      logic c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= 1'b0;
          c_q <= 1'b0;
        end else begin
          d_q <= d_next;
          c_q <= c_next;
        end
      end
      assign dout = d_q;
      assign cout = c_q;
    end else begin : g_comb
      assign dout = d_next;
      assign cout = c_next;
    end
  endgenerate
endmodule

// File: rtl/ras_so_level.sv
module ras_so_level #(
  parameter int  IN_CNT = 16,
  parameter bit  PIPE   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IN_CNT-1:0]    din,
  input  logic [IN_CNT-1:0]    cin,
  output logic [IN_CNT/4-1:0]  dout,
  output logic [IN_CNT/4-1:0]  cout
);
  localparam int GROUPS = IN_CNT / ras_so_pkg::FANIN;

  for (genvar g = 0; g < GROUPS; g++) begin : g_mc
    ras_so_macrocell #(.PIPE(PIPE)) u_mc (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (din[g*4 +: 4]),
      .cin  (cin[g*4 +: 4]),
      .dout (dout[g]),
      .cout (cout[g])
    );
  end
endmodule

// File: rtl/ras_scanout_tree.sv
module ras_scanout_tree #(
  parameter int LEVELS = 2,
  parameter bit PIPE   = 1'b1,
  localparam int NCELL = ras_so_pkg::cells_for(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] cell_data,
  input  logic [NCELL-1:0] cell_sel,
  output logic             scan_out,
  output logic             scan_valid
);
  // One vector per stage. Stage l carries NCELL >> (2*l) live entries.
  logic [NCELL-1:0] st_d [LEVELS+1];
  logic [NCELL-1:0] st_c [LEVELS+1];

  assign st_d[0] = cell_data;
  assign st_c[0] = cell_sel;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int W_IN  = NCELL >> (ras_so_pkg::FANIN_LOG2 * l);
    localparam int W_OUT = W_IN / ras_so_pkg::FANIN;

    ras_so_level #(.IN_CNT(W_IN), .PIPE(PIPE)) u_level (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (st_d[l][W_IN-1:0]),
      .cin  (st_c[l][W_IN-1:0]),
      .dout (st_d[l+1][W_OUT-1:0]),
      .cout (st_c[l+1][W_OUT-1:0])
    );

    if (W_OUT < NCELL) begin : g_pad
      assign st_d[l+1][NCELL-1:W_OUT] = '0;
      assign st_c[l+1][NCELL-1:W_OUT] = '0;
    end
  end

  assign scan_out   = st_d[LEVELS][0];
  assign scan_valid = st_c[LEVELS][0];
endmodule

// File: rtl/ras_scanout_tree_chk.sv
module ras_scanout_tree_chk #(
  parameter int LEVELS = 2,
  parameter bit PIPE   = 1'b1,
  localparam int NCELL = ras_so_pkg::cells_for(LEVELS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCELL-1:0] cell_data,
  input logic [NCELL-1:0] cell_sel,
  input logic             scan_out,
  input logic             scan_valid
);
  // Reference delay line, LEVELS deep, built independently of the tree.
  logic [LEVELS:0] ref_d;
  logic [LEVELS:0] ref_v;
  assign ref_d[0] = |(cell_data & cell_sel);
  assign ref_v[0] = |cell_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d[LEVELS:1] <= '0;
      ref_v[LEVELS:1] <= '0;
    end else begin
      ref_d[LEVELS:1] <= ref_d[LEVELS-1:0];
      ref_v[LEVELS:1] <= ref_v[LEVELS-1:0];
    end
  end

  logic tap_d, tap_v;
  assign tap_d = PIPE ? ref_d[LEVELS] : ref_d[0];
  assign tap_v = PIPE ? ref_v[LEVELS] : ref_v[0];

  AST_DATA_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == tap_d); // R1
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid == tap_v); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_valid |-> !scan_out); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE && $rose(rst_n)) |-> (!scan_out && !scan_valid)); // R6
endmodule

bind ras_scanout_tree ras_scanout_tree_chk #(.LEVELS(LEVELS), .PIPE(PIPE)) u_chk (.*);

// File: tb/ras_scanout_tree_bench.sv
module ras_scanout_tree_bench;
  localparam int LEVELS = 2;
  localparam int NCELL  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCELL-1:0] cell_data = '0;
  logic [NCELL-1:0] cell_sel  = '0;
  logic out_p, val_p, out_c, val_c;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ras_scanout_tree #(.LEVELS(LEVELS), .PIPE(1'b1)) u_ras_scanout_tree (
    .clk(clk), .rst_n(rst_n), .cell_data(cell_data), .cell_sel(cell_sel),
    .scan_out(out_p), .scan_valid(val_p));

  ras_scanout_tree #(.LEVELS(LEVELS), .PIPE(1'b0)) u_ras_scanout_tree_comb (
    .clk(clk), .rst_n(rst_n), .cell_data(cell_data), .cell_sel(cell_sel),
    .scan_out(out_c), .scan_valid(val_c));

  function automatic logic exp_out(input logic [NCELL-1:0] d, input logic [NCELL-1:0] s);
    return |(d & s);
  endfunction

  function automatic logic exp_val(input logic [NCELL-1:0] s);
    return |s;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b data=%h sel=%h", req, act, expv, cell_data, cell_sel);
    end
  endtask

  // Drive on a falling edge, check comb now, then pipelined after LEVELS rising edges.
  task automatic apply(input logic [NCELL-1:0] d, input logic [NCELL-1:0] s, input string req);
    @(negedge clk);
    cell_data = d;
    cell_sel  = s;
    #1;
    check({req, " R4 comb data"}, out_c, exp_out(d, s));
    check({req, " R4 comb valid"}, val_c, exp_val(s));
    repeat (LEVELS) @(posedge clk);
    #1;
    check({req, " R5 pipe data"}, out_p, exp_out(d, s));
    check({req, " R5 pipe valid"}, val_p, exp_val(s));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    // R6: pipelined outputs held at 0 during reset, even with a live select.
    cell_data = '1;
    cell_sel  = 16'h0001;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset data", out_p, 1'b0);
    check("R6 reset valid", val_p, 1'b0);
    @(negedge clk);
    cell_sel = '0;
    rst_n = 1'b1;

    // R1: every address, both data values, random background.
    for (int a = 0; a < NCELL; a++) begin
      for (int v = 0; v < 2; v++) begin
        logic [NCELL-1:0] d;
        d = NCELL'($urandom);
        d[a] = v[0];
        apply(d, NCELL'(1) << a, "R1 addr");
      end
    end

    // R3: nothing selected, data all ones and random.
    apply('1, '0, "R3 idle ones");
    apply(NCELL'($urandom), '0, "R3 idle rand");

    // R7: multiple selects give OR of selected data bits.
    apply(16'h0000, 16'h8001, "R7 multi zeros");
    apply(16'h0100, 16'h0111, "R7 multi one");
    apply(16'hFEFF, 16'h0100, "R1 lone zero");

    // R2: random one-hot or idle patterns.
    for (int i = 0; i < 40; i++) begin
      logic [NCELL-1:0] s;
      s = ($urandom % 4 == 0) ? '0 : (NCELL'(1) << ($urandom % NCELL));
      apply(NCELL'($urandom), s, "R2 random");
    end

    // R5: streaming, a new pattern every cycle.
    begin
      logic [NCELL-1:0] hd [24];
      logic [NCELL-1:0] hs [24];
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (i >= LEVELS) begin
          check("R5 stream data", out_p, exp_out(hd[i-LEVELS], hs[i-LEVELS]));
          check("R5 stream valid", val_p, exp_val(hs[i-LEVELS]));
        end
        hd[i] = NCELL'($urandom);
        hs[i] = ($urandom % 3 == 0) ? '0 : (NCELL'(1) << ($urandom % NCELL));
        cell_data = hd[i];
        cell_sel  = hs[i];
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule